// File: doc/BRIEF.md
# Dual-Mode Keyed Watchdog Timer

This block guards a small microcontroller against a program that has hung. Software must keep writing a 4-bit key to an 8-bit control register. If it stops, the block raises a reset pulse. The same key value starts the timer and later restarts its count. The timer has two modes, chosen by a 16-bit selection ID. The ID comes from non-volatile storage and is sampled whenever the block leaves reset.

In software mode the timer stays idle until the first keyed write. That write also fixes which of five external prescaler taps drives the count. In hardware mode the timer runs straight out of reset on the slow RC tap, and software cannot change the tap or stop the timer. Each tap arrives as a single-cycle tick. The count is coarse: the reset fires on the second selected tick after the last restart, so the timeout falls between one and two tick periods. Clearing the selected prescaler also restarts the count. Entering a standby mode restarts it too, except in one hardware variant. A second hardware variant freezes the count for as long as standby lasts.

The controller is a four-state machine:
- LOAD samples the ID and, on the next edge, goes to RUN for a hardware ID or to IDLE for the software ID.
- IDLE goes to RUN on a keyed write.
- RUN goes to BITE when the second selected tick arrives.
- BITE holds the reset output high for a fixed number of cycles, then returns to LOAD.

Top module: `keyed_wdog`

## Requirements
- R1: Control register read layout: bits 7:6 are the tap select, bit 5 is the RC-tap flag, bit 4 reads 1 in hardware mode and 0 in software mode, and bits 3:0 always read 0.
- R2: In software mode the register reads 0x00 after reset, and ticks on any line cause no reset before activation.
- R3: The ID is decoded as follows: 0xA596 selects software mode; 0xA597 selects hardware mode that freezes in standby; any other value selects hardware mode that runs through standby. In either hardware mode the register reads 0x30 and the timer counts with no write.
- R4: In software mode, the first write whose bits 3:0 equal 0101 activates the timer and latches bits 7:5 as the select fields.
- R5: Writes whose bits 3:0 are not 0101 have no effect. Select bits in any write after activation are ignored. In hardware mode the select fields are fixed at {00,1}.
- R6: While running, a write with key 0101 restarts the count, in both modes.
- R7: Tap mapping for {bits 7:6, bit 5}: {00,0} is tick line 0, {01,0} is line 1, {10,0} is line 2, {11,0} is line 3, and {xx,1} is line 4. Ticks on unselected lines are ignored.
- R8: The reset output rises in the cycle after the second selected tick that follows activation or the last restart.
- R9: A clear pulse from the prescaler group feeding the selected tap restarts the count. Group 0 feeds lines 0 and 1, group 1 feeds lines 2 and 3, and group 2 feeds line 4. Clears from other groups are ignored.
- R10: A rising edge of the standby input restarts the count, except in hardware mode with a run-through ID. With the 0xA597 ID, ticks are not counted while standby is high.
- R11: The reset pulse lasts exactly 4 cycles. After it, the block returns to its reset state and resamples the ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_id | input | 16 | Mode selection ID, sampled after reset and after each bite |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| tick_in | input | 5 | Single-cycle ticks from the five prescaler taps |
| psc_clr | input | 3 | Clear pulses from the three prescaler groups |
| standby | input | 1 | High while the system is in a standby mode |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
The bench targets the places where a count restart is easy to miss or to add by mistake:
- A prescaler clear from the wrong group. A design that accepts it would stretch the timeout.
- Standby entry in each of the three modes. A design that mixes the modes up either bites during a frozen standby or never bites during a live one.
- Select bits written after activation. A design that accepts them would move the count to a tap software should no longer reach.
- The ID swap made during a bite. A design that does not resample the ID stays in the old mode.
- The exact pulse length, which catches an off-by-one in the pulse counter.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

    localparam int ID_W       = 16;
    localparam int KEY_W      = 4;
    localparam int N_TICK     = 5;
    localparam int N_GRP      = 3;

    localparam logic [KEY_W-1:0] KEY_CODE  = 4'b0101;
    localparam logic [ID_W-1:0]  ID_SOFT   = 16'hA596;
    localparam logic [ID_W-1:0]  ID_HW_NAP = 16'hA597;

    localparam int LINE_RC   = 4;
    localparam int GRP_MAIN  = 0;
    localparam int GRP_WATCH = 1;
    localparam int GRP_RC    = 2;

    typedef enum logic [1:0] {
        MODE_SOFT,
        MODE_HW_NAP,
        MODE_HW_LIVE
    } wd_mode_t;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_IDLE,
        ST_RUN,
        ST_BITE
    } wd_state_t;

    typedef struct packed {
        logic [1:0] cs;
        logic       csp;
    } clk_sel_t;

    localparam clk_sel_t SEL_HW = '{cs: 2'b00, csp: 1'b1};

    function automatic wd_mode_t decode_id(input logic [ID_W-1:0] id);
        if (id == ID_SOFT)
            return MODE_SOFT;
        else if (id == ID_HW_NAP)
            return MODE_HW_NAP;
        else
            return MODE_HW_LIVE;
    endfunction

endpackage

// File: rtl/wdog_mode_reg.sv
module wdog_mode_reg
    import keyed_wdog_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] sel_id,
    input  logic            load,
    input  logic            arm_ok,
    input  logic            key_wr,
    input  logic [2:0]      wsel,
    output wd_mode_t        mode,
    output clk_sel_t        sel,
    output logic [7:0]      rdata
);

    wd_mode_t mode_q;
    clk_sel_t sel_q;
    logic     hw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_SOFT;
            sel_q  <= '0;
        end else if (load) begin
            mode_q <= decode_id(sel_id);
            sel_q  <= '0;
        end else if (arm_ok && key_wr && mode_q == MODE_SOFT) begin
            sel_q  <= clk_sel_t'(wsel);
        end
    end

    always_comb begin
        hw    = (mode_q != MODE_SOFT);
        mode  = mode_q;
        sel   = hw ? SEL_HW : sel_q;
        rdata = {sel.cs, sel.csp, hw, 4'b0000};
    end

endmodule

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
    import keyed_wdog_pkg::*;
(
    input  clk_sel_t          sel,
    input  logic [N_TICK-1:0] tick_in,
    input  logic [N_GRP-1:0]  psc_clr,
    output logic              tick_hit,
    output logic              src_clr
);

    always_comb begin
        if (sel.csp) begin
            tick_hit = tick_in[LINE_RC];
            src_clr  = psc_clr[GRP_RC];
        end else begin
            unique case (sel.cs)
                2'b00: tick_hit = tick_in[0];
                2'b01: tick_hit = tick_in[1];
                2'b10: tick_hit = tick_in[2];
                2'b11: tick_hit = tick_in[3];
            endcase
            src_clr = sel.cs[1] ? psc_clr[GRP_WATCH] : psc_clr[GRP_MAIN];
        end
    end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import keyed_wdog_pkg::*;
#(
    parameter int PULSE_LEN  = 4,
    parameter int BITE_TICKS = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     id_hw,
    input  wd_mode_t mode,
    input  logic     key_wr,
    input  logic     tick_hit,
    input  logic     src_clr,
    input  logic     standby,
    output logic     load,
    output logic     arm_ok,
    output logic     bite
);

    localparam int PC_W  = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam int CNT_W = $clog2(BITE_TICKS + 1);
    localparam logic [PC_W-1:0]  PC_LAST  = PC_W'(PULSE_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BITE_TICKS - 1);

    wd_state_t        state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [PC_W-1:0]  pc;
    logic             stby_q;
    logic             frozen, tick_eff, stby_clr, clr_now, bite_now;

    always_comb begin
        frozen   = (mode == MODE_HW_NAP) && standby;
        tick_eff = tick_hit && !frozen;
        stby_clr = standby && !stby_q && (mode != MODE_HW_LIVE);
        clr_now  = key_wr || src_clr || stby_clr;
        bite_now = tick_eff && !clr_now && (cnt == CNT_LAST);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOAD: nxt = id_hw ? ST_RUN : ST_IDLE;
            ST_IDLE: if (key_wr) nxt = ST_RUN;
            ST_RUN:  if (bite_now) nxt = ST_BITE;
            ST_BITE: if (pc == PC_LAST) nxt = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_LOAD;
        else
            state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            pc     <= '0;
            stby_q <= 1'b0;
        end else begin
            stby_q <= standby;
            if (state != ST_RUN || clr_now)
                cnt <= '0;
            else if (tick_eff)
                cnt <= cnt + 1'b1;
            if (state == ST_BITE)
                pc <= pc + 1'b1;
            else
                pc <= '0;
        end
    end

    always_comb begin
        load   = (state == ST_LOAD);
        arm_ok = (state == ST_IDLE);
        bite   = (state == ST_BITE);
    end

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int PULSE_LEN  = 4,
    parameter int BITE_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   sel_id,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [N_TICK-1:0] tick_in,
    input  logic [N_GRP-1:0]  psc_clr,
    input  logic              standby,
    output logic              wdt_rst
);

    wd_mode_t mode;
    clk_sel_t sel;
    logic     key_wr, id_hw, load, arm_ok, tick_hit, src_clr;
    logic     unused_wbit;

    assign key_wr      = reg_we && (reg_wdata[KEY_W-1:0] == KEY_CODE);
    assign id_hw       = (decode_id(sel_id) != MODE_SOFT);
    assign unused_wbit = reg_wdata[4];

    wdog_mode_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_id (sel_id),
        .load   (load),
        .arm_ok (arm_ok),
        .key_wr (key_wr),
        .wsel   (reg_wdata[7:5]),
        .mode   (mode),
        .sel    (sel),
        .rdata  (reg_rdata)
    );

    wdog_tick_sel u_sel (
        .sel      (sel),
        .tick_in  (tick_in),
        .psc_clr  (psc_clr),
        .tick_hit (tick_hit),
        .src_clr  (src_clr)
    );

    wdog_core #(
        .PULSE_LEN  (PULSE_LEN),
        .BITE_TICKS (BITE_TICKS)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .id_hw    (id_hw),
        .mode     (mode),
        .key_wr   (key_wr),
        .tick_hit (tick_hit),
        .src_clr  (src_clr),
        .standby  (standby),
        .load     (load),
        .arm_ok   (arm_ok),
        .bite     (wdt_rst)
    );

endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] tick_in,
    input logic [7:0] reg_rdata,
    input logic       wdt_rst
);

    // R11: the pulse is exactly four cycles wide
    assert_pulse_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst) |=> wdt_rst ##1 wdt_rst ##1 wdt_rst ##1 !wdt_rst);

    // R8: a bite only follows a cycle that carried a tick
    assert_bite_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst) |-> $past(|tick_in));

    // R1: the key nibble never reads back
    assert_key_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[3:0] == 4'b0000);

    // R5: with the hardware flag set, the select fields are pinned
    assert_hw_sel_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[4] |-> reg_rdata[7:5] == 3'b001);

    // R5: once latched, the select fields hold until a bite
    assert_sel_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_rdata[7:5]) != 3'b000 && !$past(wdt_rst) && !$past(wdt_rst, 2) && !wdt_rst)
        |-> $stable(reg_rdata[7:5]));

    // R3: the mode flag only moves around a bite
    assert_mode_flag_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wdt_rst) && !$past(wdt_rst, 2) && $past(reg_rdata[7:5]) != 3'b000)
        |-> $stable(reg_rdata[4]));

endmodule

bind keyed_wdog keyed_wdog_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_in   (tick_in),
    .reg_rdata (reg_rdata),
    .wdt_rst   (wdt_rst)
);

// File: tb/tb_keyed_wdog.sv
`timescale 1ns/1ps
module tb_keyed_wdog;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sel_id = 16'hA596;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [4:0]  tick_in = '0;
    logic [2:0]  psc_clr = '0;
    logic        standby = 1'b0;
    logic        wdt_rst;

    always #4 clk = ~clk;

    keyed_wdog dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_id    (sel_id),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tick_in   (tick_in),
        .psc_clr   (psc_clr),
        .standby   (standby),
        .wdt_rst   (wdt_rst)
    );

    typedef struct {
        bit         is_rst;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    // monitor: compares queued expectations on the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t      it;
            logic [7:0] act;
            it  = q.pop_front();
            act = it.is_rst ? {7'b0, wdt_rst} : reg_rdata;
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic exp_rd(input logic [7:0] e, input string tag);
        item_t it;
        it.is_rst = 1'b0; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic exp_bite(input logic e, input string tag);
        item_t it;
        it.is_rst = 1'b1; it.exp = {7'b0, e}; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_we = 1'b1; reg_wdata = d;
        cyc();
        reg_we = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic tick(input int line);
        tick_in[line] = 1'b1;
        cyc();
        tick_in = '0;
    endtask

    task automatic pclr(input int grp);
        psc_clr[grp] = 1'b1;
        cyc();
        psc_clr = '0;
    endtask

    // called right after the bite edge; new_id is sampled at the reload
    task automatic pulse_tail(input logic [15:0] new_id, input string tag);
        sel_id = new_id;
        standby = 1'b0;
        cyc(); exp_bite(1'b1, {tag, " R11 pulse cycle 2"});
        cyc(); exp_bite(1'b1, {tag, " R11 pulse cycle 3"});
        cyc(); exp_bite(1'b1, {tag, " R11 pulse cycle 4"});
        cyc(); exp_bite(1'b0, {tag, " R11 pulse ends after 4"});
        cyc();
    endtask

    initial begin
        // software mode out of reset
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        exp_rd(8'h00, "R2 soft reset value");
        exp_bite(1'b0, "R2 no reset at start");
        tick(4); tick(4); tick(0); tick(4);
        exp_bite(1'b0, "R2 idle ignores ticks");
        wr(8'hC0);
        exp_rd(8'h00, "R5 unkeyed write ignored");
        wr(8'hC5);
        exp_rd(8'hC0, "R4 activation latches select, R1 key reads 0");
        wr(8'h05);
        exp_rd(8'hC0, "R5 select frozen after activation");
        tick(0); tick(1); tick(2); tick(4);
        exp_bite(1'b0, "R7 unselected lines ignored");
        tick(3);
        exp_bite(1'b0, "R8 first tick no bite");
        wr(8'h05);
        tick(3);
        exp_bite(1'b0, "R6 key restart");
        tick(3);
        exp_bite(1'b1, "R8 second tick bites");
        pulse_tail(16'h1234, "soft");

        // hardware run-through mode
        exp_rd(8'h30, "R3 live hardware reads 0x30 and R11 resample");
        tick(4);
        pclr(2);
        tick(4);
        exp_bite(1'b0, "R9 selected group clear");
        wr(8'hE5);
        exp_rd(8'h30, "R5 hardware select read-only");
        tick(4);
        exp_bite(1'b0, "R6 key restart in hardware");
        tick(0);
        exp_bite(1'b0, "R7 line 0 ignored in hardware");
        tick(4);
        exp_bite(1'b1, "R3 hardware counts with no write");
        pulse_tail(16'h1234, "hw live");
        tick(4);
        standby = 1'b1;
        cyc();
        tick(4);
        exp_bite(1'b1, "R10 live hardware counts through standby");
        pulse_tail(16'hA597, "hw live stby");

        // hardware mode frozen in standby
        exp_rd(8'h30, "R3 nap hardware reads 0x30");
        tick(4);
        standby = 1'b1;
        cyc();
        tick(4); tick(4); tick(4);
        exp_bite(1'b0, "R10 nap frozen in standby");
        standby = 1'b0;
        cyc();
        tick(4);
        exp_bite(1'b0, "R10 nap standby entry restarts");
        tick(4);
        exp_bite(1'b1, "R10 nap bites after wake");
        pulse_tail(16'hA596, "hw nap");

        // software mode, RC tap, standby entry restart
        exp_rd(8'h00, "R11 back to soft reset value");
        wr(8'h25);
        exp_rd(8'h20, "R4 RC tap latched");
        tick(4);
        standby = 1'b1;
        cyc();
        tick(4);
        exp_bite(1'b0, "R10 soft standby entry restarts");
        tick(4);
        exp_bite(1'b1, "R10 soft counts in standby");
        pulse_tail(16'hA596, "soft stby");

        // watch tap, clears from the wrong and right groups
        wr(8'h85);
        exp_rd(8'h80, "R4 watch tap latched");
        tick(2);
        pclr(0);
        pclr(2);
        tick(2);
        exp_bite(1'b1, "R9 other group clears ignored");
        pulse_tail(16'hA596, "soft watch");
        wr(8'h85);
        tick(2);
        pclr(1);
        tick(2);
        exp_bite(1'b0, "R9 watch group clear restarts");
        tick(2);
        exp_bite(1'b1, "R7 line 2 drives count");
        pulse_tail(16'hA596, "soft watch 2");

        @(negedge clk);
        #1;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule